// File: doc/BRIEF.md
# Serial Control and Status Port

This block is the serial slave front end of a six-channel output driver. A host frames each transfer with an active-low chip select and clocks data with a serial clock. Command bits arrive on the data input least significant bit first and are collected in a receive shift register. A parallel status word is sent back on the data output at the same time, also least significant bit first. The received word becomes the committed command only when chip select rises after exactly one full word. An aborted or overlong frame changes nothing.

All serial inputs are resynchronized into the system clock domain. The block assumes the system clock runs at least eight times faster than the serial clock. Right after chip select falls, the data output shows status bit 0, the temperature-warning flag. A host can therefore poll that flag by pulling chip select low and releasing it again without any clock pulses. A committed command whose bit 0 is set also produces a one-cycle clear request toward the status logic.

Top module: `serdrv_ctl_port`

## Requirements
- R1: `sdo_oe_o` is 0 while `cs_n_i` is high and becomes 1 after `cs_n_i` falls. It returns to 0 after `cs_n_i` rises.
- R2: After `cs_n_i` falls, and before any serial clock edge, `sdo_o` shows bit 0 of `status_i` as sampled at the chip-select fall.
- R3: Each rising `sclk_i` edge inside a frame advances `sdo_o` to the next higher status bit. A frame sends bits 0 to 15 of the word captured at the chip-select fall, and later changes of `status_i` during the frame are not sent.
- R4: `sdi_i` is sampled on falling `sclk_i` edges. The first sampled bit lands in `cmd_o[0]` and the sixteenth in `cmd_o[15]`.
- R5: `cmd_o` changes only on a rising `cs_n_i` that closes a frame of exactly 16 falling clock edges. Frames with fewer or more edges leave `cmd_o` unchanged.
- R6: `clr_stat_o` pulses high for exactly one system cycle when a committed command has bit 0 set. It stays low for a committed command with bit 0 clear and for a discarded frame.
- R7: After reset, `cmd_o` is 16'hE000: bits 13 (open-load check disable, active low enable), 14 (long delay select) and 15 (run) are high, and all other bits are low. `sdo_oe_o` and `clr_stat_o` are 0 after reset.
- R8: A chip-select pulse with no clock edges leaves `cmd_o` unchanged and produces no `clr_stat_o` pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n_i | input | 1 | Serial chip select, active low |
| sclk_i | input | 1 | Serial clock, idles low |
| sdi_i | input | 1 | Serial command data in |
| status_i | input | 16 | Status word to send |
| sdo_o | output | 1 | Serial status data out |
| sdo_oe_o | output | 1 | Drive enable for the data output pad |
| cmd_o | output | 16 | Committed command word |
| clr_stat_o | output | 1 | One-cycle status clear request |

## Verification
The bench builds the block with a 16-bit word, two synchronizer stages and the 16'hE000 power-on command. In that setup the 5-bit bit counter can be driven past the full-word value: a 17-edge frame must be rejected, and so must 8-edge and zero-edge frames. The serial clock runs at one sixteenth of the system clock, twice the required margin. This lets the bench sample each status bit and check each committed command well clear of the synchronizer latency.

// File: rtl/sdp_pkg.sv
package sdp_pkg;
   localparam int unsigned CMD_W       = 16;
   localparam int unsigned CLR_BIT     = 0;
   localparam logic [CMD_W-1:0] CMD_POR = 16'hE000;
endpackage

// File: rtl/sdp_sync.sv
module sdp_sync #(
   parameter int unsigned W      = 3,
   parameter int unsigned STAGES = 2,
   parameter logic [W-1:0] RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   generate
      if (STAGES < 2) begin : g_bad
         $error("sdp_sync needs at least two stages");
      end
   endgenerate

   logic [W-1:0] stg [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < STAGES; i++) stg[i] <= RST_VAL;
      end else begin
         stg[0] <= d;
         for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
      end
   end

   assign q = stg[STAGES-1];
endmodule

// File: rtl/sdp_frame.sv
module sdp_frame #(
   parameter int unsigned WORD_W = 16,
   localparam int unsigned CNT_W = $clog2(WORD_W + 2)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cs_s,
   input  logic              sclk_s,
   input  logic              sdi_s,
   input  logic [WORD_W-1:0] status_i,
   output logic              sdo_o,
   output logic              sdo_oe_o,
   output logic [WORD_W-1:0] rx_word,
   output logic              cs_fall,
   output logic              cs_rise,
   output logic              commit
);
   localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(WORD_W);
   localparam logic [CNT_W-1:0] CNT_MAX  = '1;

   logic              cs_d, sclk_d;
   logic [CNT_W-1:0]  bit_cnt;
   logic [WORD_W-1:0] tx_sr;
   logic              sclk_rise, sclk_fall;

   assign cs_fall   = cs_d & ~cs_s;
   assign cs_rise   = ~cs_d & cs_s;
   assign sclk_rise = ~sclk_d & sclk_s;
   assign sclk_fall = sclk_d & ~sclk_s;
   assign commit    = cs_rise && (bit_cnt == CNT_FULL);
   assign sdo_o     = tx_sr[0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cs_d     <= 1'b1;
         sclk_d   <= 1'b0;
         bit_cnt  <= '0;
         rx_word  <= '0;
         tx_sr    <= '0;
         sdo_oe_o <= 1'b0;
      end else begin
         cs_d   <= cs_s;
         sclk_d <= sclk_s;
         if (cs_fall) begin
            tx_sr    <= status_i;
            bit_cnt  <= '0;
            sdo_oe_o <= 1'b1;
         end else if (cs_rise) begin
            sdo_oe_o <= 1'b0;
         end else if (!cs_s) begin
            if (sclk_fall) begin
               rx_word <= {sdi_s, rx_word[WORD_W-1:1]};
               if (bit_cnt != CNT_MAX) bit_cnt <= bit_cnt + 1'b1;
            end
            if (sclk_rise) tx_sr <= {1'b0, tx_sr[WORD_W-1:1]};
         end
      end
   end
endmodule

// File: rtl/sdp_cmd_reg.sv
module sdp_cmd_reg #(
   parameter int unsigned WORD_W = 16,
   parameter int unsigned CLR_BIT = 0,
   parameter logic [WORD_W-1:0] POR_VAL = '0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              commit,
   input  logic [WORD_W-1:0] rx_word,
   output logic [WORD_W-1:0] cmd_o,
   output logic              clr_o
);
   generate
      if (CLR_BIT >= WORD_W) begin : g_bad
         $error("clear bit outside command word");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cmd_o <= POR_VAL;
         clr_o <= 1'b0;
      end else if (commit) begin
         cmd_o <= rx_word;
         clr_o <= rx_word[CLR_BIT];
      end else begin
         clr_o <= 1'b0;
      end
   end
endmodule

// File: rtl/serdrv_ctl_port.sv
module serdrv_ctl_port #(
   parameter int unsigned WORD_W      = sdp_pkg::CMD_W,
   parameter int unsigned SYNC_STAGES = 2,
   parameter int unsigned CLR_BIT     = sdp_pkg::CLR_BIT,
   parameter logic [WORD_W-1:0] POR_VAL = sdp_pkg::CMD_POR
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cs_n_i,
   input  logic              sclk_i,
   input  logic              sdi_i,
   input  logic [WORD_W-1:0] status_i,
   output logic              sdo_o,
   output logic              sdo_oe_o,
   output logic [WORD_W-1:0] cmd_o,
   output logic              clr_stat_o
);
   generate
      if (WORD_W < 2) begin : g_bad
         $error("word width must be at least 2");
      end
   endgenerate

   logic [2:0]        sync_q;
   logic [WORD_W-1:0] rx_word;
   logic              cs_fall, cs_rise, commit;

   sdp_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) u_sync (
      .clk(clk), .rst_n(rst_n),
      .d({cs_n_i, sclk_i, sdi_i}), .q(sync_q)
   );

   sdp_frame #(.WORD_W(WORD_W)) u_frame (
      .clk(clk), .rst_n(rst_n),
      .cs_s(sync_q[2]), .sclk_s(sync_q[1]), .sdi_s(sync_q[0]),
      .status_i(status_i), .sdo_o(sdo_o), .sdo_oe_o(sdo_oe_o),
      .rx_word(rx_word), .cs_fall(cs_fall), .cs_rise(cs_rise),
      .commit(commit)
   );

   sdp_cmd_reg #(.WORD_W(WORD_W), .CLR_BIT(CLR_BIT), .POR_VAL(POR_VAL)) u_cmd (
      .clk(clk), .rst_n(rst_n), .commit(commit), .rx_word(rx_word),
      .cmd_o(cmd_o), .clr_o(clr_stat_o)
   );
endmodule

// File: rtl/sdp_checker.sv
module sdp_checker #(
   parameter int unsigned WORD_W = 16,
   parameter int unsigned CLR_BIT = 0
) (
   input logic              clk,
   input logic              rst_n,
   input logic              cs_fall,
   input logic              cs_rise,
   input logic              commit,
   input logic [WORD_W-1:0] status_i,
   input logic [WORD_W-1:0] rx_word,
   input logic              sdo_o,
   input logic              sdo_oe_o,
   input logic [WORD_W-1:0] cmd_o,
   input logic              clr_stat_o
);
   p_oe_on_r1: assert property (@(posedge clk) disable iff (!rst_n)
      cs_fall |=> sdo_oe_o);
   p_oe_off_r1: assert property (@(posedge clk) disable iff (!rst_n)
      cs_rise |=> !sdo_oe_o);
   p_first_bit_r2: assert property (@(posedge clk) disable iff (!rst_n)
      cs_fall |=> (sdo_o == $past(status_i[0])));
   p_cmd_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !commit |=> $stable(cmd_o));
   p_commit_load_r4: assert property (@(posedge clk) disable iff (!rst_n)
      commit |=> (cmd_o == $past(rx_word)));
   p_clr_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
      clr_stat_o |=> !clr_stat_o);
   p_clr_cause_r6: assert property (@(posedge clk) disable iff (!rst_n)
      clr_stat_o |-> ($past(commit) && cmd_o[CLR_BIT]));
endmodule

bind serdrv_ctl_port sdp_checker #(.WORD_W(WORD_W), .CLR_BIT(CLR_BIT)) u_chk (
   .clk(clk), .rst_n(rst_n), .cs_fall(cs_fall), .cs_rise(cs_rise),
   .commit(commit), .status_i(status_i), .rx_word(rx_word), .sdo_o(sdo_o),
   .sdo_oe_o(sdo_oe_o), .cmd_o(cmd_o), .clr_stat_o(clr_stat_o)
);

// File: tb/tb_serdrv_ctl_port.sv
module tb_serdrv_ctl_port;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cs_n_i = 1'b1, sclk_i = 1'b0, sdi_i = 1'b0;
   logic [15:0] status_i = '0;
   logic        sdo_o, sdo_oe_o, clr_stat_o;
   logic [15:0] cmd_o;

   int n_chk = 0, n_fail = 0, n_clr = 0;
   logic [15:0] exp_cmd;

   localparam int HALF = 8;

   always #10 clk = ~clk;

   serdrv_ctl_port dut (
      .clk(clk), .rst_n(rst_n), .cs_n_i(cs_n_i), .sclk_i(sclk_i),
      .sdi_i(sdi_i), .status_i(status_i), .sdo_o(sdo_o),
      .sdo_oe_o(sdo_oe_o), .cmd_o(cmd_o), .clr_stat_o(clr_stat_o)
   );

   always @(posedge clk) if (rst_n && clr_stat_o) n_clr++;

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wait_clk(input int n);
      repeat (n) @(negedge clk);
   endtask

   // frame of nbits clock pulses; returns status bits seen on sdo
   task automatic frame(input logic [31:0] data, input int nbits, output logic [15:0] rd);
      rd = '0;
      cs_n_i = 1'b0;
      wait_clk(HALF);
      rd[0] = sdo_o;
      for (int i = 0; i < nbits; i++) begin
         sdi_i  = data[i];
         sclk_i = 1'b1;
         wait_clk(HALF);
         if (i + 1 < 16) rd[i+1] = sdo_o;
         sclk_i = 1'b0;
         wait_clk(HALF);
      end
      cs_n_i = 1'b1;
      wait_clk(HALF);
   endtask

   task automatic t_reset;
      chk(cmd_o == 16'hE000, "R7 cmd reset", cmd_o, 16'hE000);
      chk(sdo_oe_o == 1'b0, "R7/R1 oe reset", sdo_oe_o, 0);
      chk(clr_stat_o == 1'b0, "R7 clr reset", clr_stat_o, 0);
   endtask

   task automatic t_short_read;
      logic [15:0] rd;
      int c0 = n_clr;
      status_i = 16'h0001;
      cs_n_i = 1'b0;
      wait_clk(HALF);
      chk(sdo_oe_o == 1'b1, "R1 oe after fall", sdo_oe_o, 1);
      chk(sdo_o == 1'b1, "R2 warning bit shown", sdo_o, 1);
      cs_n_i = 1'b1;
      wait_clk(HALF);
      chk(sdo_oe_o == 1'b0, "R1 oe after rise", sdo_oe_o, 0);
      chk(cmd_o == exp_cmd, "R8 cmd kept", cmd_o, exp_cmd);
      chk(n_clr == c0, "R8 no clear", n_clr, c0);
      status_i = 16'h0000;
      frame(32'h0, 0, rd);
      chk(rd[0] == 1'b0, "R2 warning low", rd[0], 0);
   endtask

   task automatic t_full(input logic [15:0] cmd, input logic [15:0] st);
      logic [15:0] rd;
      int c0 = n_clr;
      status_i = st;
      cs_n_i = 1'b0;
      wait_clk(2);
      cs_n_i = 1'b1;
      wait_clk(HALF);
      frame({16'h0, cmd}, 16, rd);
      exp_cmd = cmd;
      chk(rd == st, "R3 status out", rd, st);
      chk(cmd_o == cmd, "R4/R5 commit", cmd_o, cmd);
      chk(n_clr - c0 == int'(cmd[0]), "R6 clear count", n_clr - c0, cmd[0]);
   endtask

   task automatic t_status_capture;
      logic [15:0] rd;
      status_i = 16'h5A3C;
      cs_n_i = 1'b0;
      wait_clk(HALF);
      status_i = 16'hFFFF;
      for (int i = 0; i < 15; i++) begin
         sclk_i = 1'b1; wait_clk(HALF);
         rd[i+1] = sdo_o;
         sclk_i = 1'b0; wait_clk(HALF);
      end
      rd[0] = 1'b0;
      cs_n_i = 1'b1;
      wait_clk(HALF);
      chk(rd[15:1] == 15'h2D1E, "R3 captured at fall", rd[15:1], 15'h2D1E);
      chk(cmd_o == exp_cmd, "R5 15 edges discarded", cmd_o, exp_cmd);
   endtask

   task automatic t_bad_len(input int nbits);
      logic [15:0] rd;
      int c0 = n_clr;
      frame(32'h1_FFFF, nbits, rd);
      chk(cmd_o == exp_cmd, "R5 wrong length kept", cmd_o, exp_cmd);
      chk(n_clr == c0, "R6 no clear on discard", n_clr, c0);
   endtask

   initial begin
      exp_cmd = 16'hE000;
      wait_clk(5);
      t_reset();
      rst_n = 1'b1;
      wait_clk(5);
      t_reset();
      t_short_read();
      t_full(16'hC07E, 16'hA5C3);
      t_full(16'h2015, 16'h8001);
      t_full(16'h8001, 16'h7FFE);
      t_bad_len(8);
      t_bad_len(17);
      t_status_capture();
      t_full(16'h0000, 16'h0000);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      #(20 * 150000);
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%h expected=%h", 0, 1);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule